// File: doc/BRIEF.md
# Banked Control Register File

This block keeps the control state of a small processor core and exposes it through one numbered register port. The registers are a status word, a backup status byte and a second-level backup status byte, a condition flag, an interrupt-mode stack pointer and a user-mode stack pointer, two saved program counters and two spare 32-bit words. Reads are combinational from the index. Writes take effect at the rising clock edge.

The stack pointer that the integer datapath uses is held here as a live register. It is shown on `sp_out` and can be loaded through `sp_we`/`sp_wdata`. Bit 7 of the live status byte selects the stack mode. When a status-word write flips that bit, the live pointer is parked in the bank of the mode being left, and the live pointer is refilled from the bank of the mode being entered. The stack index that belongs to the current mode is an alias of the live pointer. The other stack index reaches the parked copy.

Top module: `ctrl_regbank`

## Requirements
- R1: While `rst_n` is low, every register clears to zero. After reset, every index reads 0, `sp_out` is 0 and the stack mode is 0.
- R2: Index 0 (status word) reads as follows. Bits 15:8 hold the backup status byte ANDed with 0xC1. Bits 7:6 hold bits 7:6 of the live status byte. Bit 0 holds the condition flag. All other bits read 0.
- R3: A write to index 0 loads the backup status byte from data bits 15:8 and the live status byte from data bits 7:0. It also loads the condition flag from data bit 0.
- R4: A write to index 0 that changes the stack mode from 0 to 1 stores the live pointer into the interrupt-stack bank and loads the live pointer from the user-stack bank.
- R5: A write to index 0 that changes the stack mode from 1 to 0 stores the live pointer into the user-stack bank and loads the live pointer from the interrupt-stack bank.
- R6: Index 2 (interrupt stack) aliases the live pointer in mode 0 and reaches the parked copy in mode 1. Index 3 (user stack) aliases the live pointer in mode 1 and reaches the parked copy in mode 0. The alias applies to both reads and writes.
- R7: Index 6 and index 7 (saved program counters) store all 32 written bits. Both always read with bit 0 forced to 0.
- R8: Index 8 (second-level backup status) stores data bits 7:0 and reads only the bits under mask 0xC1.
- R9: Index 1 reads the condition flag in bit 0, with all other bits 0. A write to index 1 sets the flag from data bit 0 and changes nothing else.
- R10: Indices 4 and 5 are plain 32-bit storage that reads back exactly what was written.
- R11: Indices 9 to 15 read 0, and writes to them leave every register unchanged.
- R12: With `sp_we` high, the live pointer takes `sp_wdata` at the clock edge, unless a control-register write in the same cycle also changes the live pointer (an alias write or a mode swap). In that case the control-register write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_idx | input | 4 | Control register index |
| cr_we | input | 1 | Control register write enable |
| cr_wdata | input | 32 | Control register write data |
| cr_rdata | output | 32 | Combinational read data for `cr_idx` |
| sp_we | input | 1 | Live stack pointer write enable from the register file |
| sp_wdata | input | 32 | Live stack pointer write data |
| sp_out | output | 32 | Live stack pointer |

## Verification
Directed sequences preload distinct values into the live pointer and both banks and then toggle the stack mode in each direction. This separates a correct swap from a swap in the wrong direction or a missing save. A walk over all sixteen indices after reset and during traffic exposes wrong masks on the status, backup and saved-PC reads. It also shows any undefined index that leaks data. A long stretch of random indices, data and simultaneous stack-port writes is compared every cycle against a behavioural model. That stretch covers the alias routing in both modes, the collision priority and write isolation between indices.

// File: rtl/ctrl_regbank.sv
module ctrl_regbank #(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cr_idx,
  input  logic          cr_we,
  input  logic [DW-1:0] cr_wdata,
  output logic [DW-1:0] cr_rdata,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_wdata,
  output logic [DW-1:0] sp_out
);
  localparam logic [IW-1:0] I_STAT  = IW'(0);
  localparam logic [IW-1:0] I_COND  = IW'(1);
  localparam logic [IW-1:0] I_ISP   = IW'(2);
  localparam logic [IW-1:0] I_USP   = IW'(3);
  localparam logic [IW-1:0] I_SPA   = IW'(4);
  localparam logic [IW-1:0] I_SPB   = IW'(5);
  localparam logic [IW-1:0] I_PC1   = IW'(6);
  localparam logic [IW-1:0] I_PC2   = IW'(7);
  localparam logic [IW-1:0] I_BBST  = IW'(8);
  localparam logic [7:0]    BK_MASK = 8'hC1;

  logic [7:0]    bst_q, st_q, bbst_q;
  logic          cond_q;
  logic [DW-1:0] sp_q, isp_q, usp_q, pc1_q, pc2_q, spa_q, spb_q;

  logic sm, wr_stat, swap, wr_live;
  assign sm      = st_q[7];
  assign wr_stat = cr_we && (cr_idx == I_STAT);
  assign swap    = wr_stat && (cr_wdata[7] != sm);
  assign wr_live = cr_we && (((cr_idx == I_ISP) && !sm) || ((cr_idx == I_USP) && sm));
  assign sp_out  = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst_q  <= '0;
      st_q   <= '0;
      bbst_q <= '0;
      cond_q <= 1'b0;
      sp_q   <= '0;
      isp_q  <= '0;
      usp_q  <= '0;
      pc1_q  <= '0;
      pc2_q  <= '0;
      spa_q  <= '0;
      spb_q  <= '0;
    end else begin
      if (wr_stat) begin
        bst_q  <= cr_wdata[15:8];
        st_q   <= cr_wdata[7:0];
        cond_q <= cr_wdata[0];
        if (swap) begin
          if (sm) begin
            usp_q <= sp_q;
            sp_q  <= isp_q;
          end else begin
            isp_q <= sp_q;
            sp_q  <= usp_q;
          end
        end
      end
      if (cr_we && (cr_idx == I_COND)) cond_q <= cr_wdata[0];
      if (cr_we && (cr_idx == I_ISP) && sm)  isp_q <= cr_wdata;
      if (cr_we && (cr_idx == I_USP) && !sm) usp_q <= cr_wdata;
      if (cr_we && (cr_idx == I_PC1))  pc1_q  <= cr_wdata;
      if (cr_we && (cr_idx == I_PC2))  pc2_q  <= cr_wdata;
      if (cr_we && (cr_idx == I_SPA))  spa_q  <= cr_wdata;
      if (cr_we && (cr_idx == I_SPB))  spb_q  <= cr_wdata;
      if (cr_we && (cr_idx == I_BBST)) bbst_q <= cr_wdata[7:0];
      if (wr_live) sp_q <= cr_wdata;
      else if (sp_we && !swap) sp_q <= sp_wdata;
    end
  end

  always_comb begin
    cr_rdata = '0;
    case (cr_idx)
      I_STAT: begin
        cr_rdata[15:8] = bst_q & BK_MASK;
        cr_rdata[7:6]  = st_q[7:6];
        cr_rdata[0]    = cond_q;
      end
      I_COND: cr_rdata[0] = cond_q;
      I_ISP:  cr_rdata = sm ? isp_q : sp_q;
      I_USP:  cr_rdata = sm ? sp_q : usp_q;
      I_SPA:  cr_rdata = spa_q;
      I_SPB:  cr_rdata = spb_q;
      I_PC1:  cr_rdata = {pc1_q[DW-1:1], 1'b0};
      I_PC2:  cr_rdata = {pc2_q[DW-1:1], 1'b0};
      I_BBST: cr_rdata[7:0] = bbst_q & BK_MASK;
      default: cr_rdata = '0;
    endcase
  end

  // R4
  enter_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !sm && cr_wdata[7]) |=> (sp_out == $past(usp_q)) && (isp_q == $past(sp_q)));
  // R5
  leave_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && sm && !cr_wdata[7]) |=> (sp_out == $past(isp_q)) && (usp_q == $past(sp_q)));
  // R7
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_idx == I_PC1) || (cr_idx == I_PC2)) |-> (cr_rdata[0] == 1'b0));
  // R11
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_idx > I_BBST) |-> (cr_rdata == '0));
  // R11
  undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && (cr_idx > I_BBST) && !sp_we) |=> $stable(sp_out) && $stable(st_q) && $stable(cond_q));
  // R12
  sp_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && !(cr_we && (cr_idx <= I_USP) && (cr_idx != I_COND))) |=> (sp_out == $past(sp_wdata)));
  // R12
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_we && !cr_we) |=> $stable(sp_out));
endmodule

// File: tb/ctrl_regbank_tb.sv
module ctrl_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cr_idx = '0;
  logic        cr_we = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata;
  logic        sp_we = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic [31:0] sp_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ctrl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .cr_idx(cr_idx), .cr_we(cr_we), .cr_wdata(cr_wdata),
    .cr_rdata(cr_rdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_out(sp_out)
  );

  // behavioural model: visible registers by name, mode tracked as a flag
  bit [31:0] m_live, m_intr, m_user, m_pc1, m_pc2, m_w4, m_w5;
  bit [7:0]  m_bk, m_st, m_bb;
  bit        m_c;

  function automatic bit [31:0] m_read(input int i);
    bit mode = m_st[7];
    case (i)
      0: return {16'h0, m_bk & 8'hC1, m_st & 8'hC0} | {31'h0, m_c};
      1: return {31'h0, m_c};
      2: return mode ? m_intr : m_live;
      3: return mode ? m_live : m_user;
      4: return m_w4;
      5: return m_w5;
      6: return m_pc1 & 32'hFFFF_FFFE;
      7: return m_pc2 & 32'hFFFF_FFFE;
      8: return {24'h0, m_bb & 8'hC1};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R9";
      2, 3: return "R6";
      4, 5: return "R10";
      6, 7: return "R7";
      8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic m_update(input int i, input bit we, input bit [31:0] d, input bit spw, input bit [31:0] spd);
    bit mode = m_st[7];
    bit [31:0] live = m_live, intr = m_intr, user = m_user;
    bit live_taken = 1'b0;
    if (we) begin
      if (i == 0) begin
        m_bk = d[15:8]; m_st = d[7:0]; m_c = d[0];
        if (d[7] && !mode) begin m_intr = live; m_live = user; live_taken = 1'b1; end
        if (!d[7] && mode) begin m_user = live; m_live = intr; live_taken = 1'b1; end
      end
      else if (i == 1) m_c = d[0];
      else if (i == 2) begin if (mode) m_intr = d; else begin m_live = d; live_taken = 1'b1; end end
      else if (i == 3) begin if (!mode) m_user = d; else begin m_live = d; live_taken = 1'b1; end end
      else if (i == 4) m_w4 = d;
      else if (i == 5) m_w5 = d;
      else if (i == 6) m_pc1 = d;
      else if (i == 7) m_pc2 = d;
      else if (i == 8) m_bb = d[7:0];
    end
    if (spw && !live_taken) m_live = spd;
  endtask

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int i, input bit we, input bit [31:0] d, input bit spw, input bit [31:0] spd, input string tag);
    @(negedge clk);
    cr_idx = 4'(i); cr_we = we; cr_wdata = d; sp_we = spw; sp_wdata = spd;
    #1;
    chk((tag == "") ? tag_of(i) : tag, cr_rdata, m_read(i), "cr_rdata");
    chk((tag == "") ? "R12" : tag, sp_out, m_live, "sp_out");
    m_update(i, we, d, spw, spd);
    @(posedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every index
    for (int i = 0; i < 16; i++) step(i, 1'b0, 32'h0, 1'b0, 32'h0, "R1");
    // R3: status write and readback (also enters mode 1)
    step(0, 1'b1, 32'h1234_ABCD, 1'b0, 32'h0, "R3");
    step(0, 1'b0, 32'h0, 1'b0, 32'h0, "R3");
    step(0, 1'b1, 32'h0000_0000, 1'b0, 32'h0, "R5");
    // R4: preload live and user bank, then enter mode 1
    step(2, 1'b0, 32'h0, 1'b1, 32'h0000_0100, "R12");
    step(3, 1'b1, 32'h0000_0200, 1'b0, 32'h0, "R6");
    step(0, 1'b1, 32'h0000_0080, 1'b0, 32'h0, "R4");
    step(2, 1'b0, 32'h0, 1'b0, 32'h0, "R4");
    step(3, 1'b0, 32'h0, 1'b0, 32'h0, "R4");
    // R5: back to mode 0 with a colliding stack-port write
    step(0, 1'b1, 32'h0000_0001, 1'b1, 32'hDEAD_0000, "R5");
    step(2, 1'b0, 32'h0, 1'b0, 32'h0, "R5");
    step(3, 1'b0, 32'h0, 1'b0, 32'h0, "R5");
    // R12: alias write collides with stack port
    step(2, 1'b1, 32'h0000_0300, 1'b1, 32'hBAD0_0000, "R12");
    step(2, 1'b0, 32'h0, 1'b0, 32'h0, "R12");
    // R7 R8 R9 R10
    step(6, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R7");
    step(6, 1'b0, 32'h0, 1'b0, 32'h0, "R7");
    step(7, 1'b1, 32'h0000_0003, 1'b0, 32'h0, "R7");
    step(7, 1'b0, 32'h0, 1'b0, 32'h0, "R7");
    step(8, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R8");
    step(8, 1'b0, 32'h0, 1'b0, 32'h0, "R8");
    step(1, 1'b1, 32'h0000_0000, 1'b0, 32'h0, "R9");
    step(0, 1'b0, 32'h0, 1'b0, 32'h0, "R9");
    step(4, 1'b1, 32'hA5A5_5A5A, 1'b0, 32'h0, "R10");
    step(5, 1'b1, 32'h0F0F_F0F0, 1'b0, 32'h0, "R10");
    step(4, 1'b0, 32'h0, 1'b0, 32'h0, "R10");
    step(5, 1'b0, 32'h0, 1'b0, 32'h0, "R10");
    // R11: undefined writes, then full walk
    step(12, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R11");
    for (int i = 0; i < 16; i++) step(i, 1'b0, 32'h0, 1'b0, 32'h0, "R11");
    // mixed traffic against the model
    for (int n = 0; n < 4000; n++)
      step(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), $urandom,
           ($urandom_range(0, 3) == 0), $urandom, "");
    report();
  end
endmodule